// File: doc/BRIEF.md
# Misaligned-Access Exception Entry Controller

This block sits next to the load/store stage of a 32-bit processor. Each cycle it looks at the access the stage wants to make: its kind and the two low address bits. A halfword or word access that is not on its natural boundary is a fault. When a fault is found, the block withholds the read or write strobe in the same cycle, so the faulting instruction never reaches memory. A fault wins over an external interrupt that arrives in the same cycle; the interrupt is simply not accepted and stays pending at its source.

On the clock edge that ends a fault cycle, the block runs the hardware entry step. It copies the supervisor-mode, interrupt-enable and carry status bits into their shadow copies, and it stores the faulting instruction's PC unchanged in a backup PC register. In the following cycle it emits a one-cycle status write that keeps the mode bit and clears the other two, together with a one-cycle fetch redirect to a fixed vector.

A return strobe runs the reverse step. One cycle later the block writes the shadow bits back into the live status bits and redirects fetch to the backup PC with its two low bits forced to zero. Any access presented in the return cycle is discarded.

Top module: `align_fault_ctrl`

## Requirements
- R1: A halfword access (kind 3 signed load, 4 unsigned load, 5 store) faults when `acc_addr[1:0]` is 01 or 11, and does not fault when it is 00 or 10.
- R2: A word access (kind 6 load, 7 store) or an atomic access (kind 8 lock, a read; kind 9 unlock, a write) faults when `acc_addr[1:0]` is 01, 10 or 11, and does not fault when it is 00.
- R3: A byte access (kind 0 signed load, 1 unsigned load, 2 store) never faults, whatever the address bits are.
- R4: In a fault cycle both `mem_rd` and `mem_wr` are 0. A valid access that does not fault raises `mem_rd` (kinds 0,1,3,4,6,8) or `mem_wr` (kinds 2,5,7,9) in the same cycle.
- R5: `irq_take` is `irq_req & psw_ie` in a cycle with no fault and no return strobe, and it is 0 in a fault cycle even when `irq_req` and `psw_ie` are both 1.
- R6: At the edge that ends a fault cycle, `bk_sm`, `bk_ie` and `bk_c` take the values of `psw_sm`, `psw_ie` and `psw_c`.
- R7: The cycle after a fault, `psw_we` is 1 for one cycle with `psw_sm_nx` equal to the previous `psw_sm`, and with `psw_ie_nx` and `psw_c_nx` both 0.
- R8: At the edge that ends a fault cycle, `bpc` takes the exact `cur_pc`, including a halfword offset, so `bpc[1]` is 1 only when the instruction was not word-aligned.
- R9: The cycle after a fault, `redirect` is 1 for one cycle and `redirect_pc` equals the parameter `VEC_ADDR` (default 32'h0000_0030).
- R10: The cycle after `rte_strobe`, `redirect` is 1 and `redirect_pc` equals `bpc` with bits [1:0] cleared.
- R11: The cycle after `rte_strobe`, `psw_we` is 1 with the status outputs equal to `bk_sm`, `bk_ie` and `bk_c`, and the shadow bits and `bpc` keep their values.
- R12: In a cycle with `rte_strobe` high, no fault is taken, no memory strobe is issued and `irq_take` is 0.
- R13: After synchronous reset, `redirect`, `psw_we`, `bpc` and the shadow bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | The load/store stage presents an access |
| acc_kind | input | 4 | Access kind code (see R1 to R4) |
| acc_addr | input | 32 | Effective address of the access |
| cur_pc | input | 32 | PC of the instruction making the access |
| psw_sm | input | 1 | Live supervisor-mode bit |
| psw_ie | input | 1 | Live interrupt-enable bit |
| psw_c | input | 1 | Live carry bit |
| irq_req | input | 1 | External interrupt request |
| rte_strobe | input | 1 | Return-from-exception strobe |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| fault_taken | output | 1 | Misalignment fault accepted this cycle |
| irq_take | output | 1 | Interrupt accepted this cycle |
| redirect | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Target PC of the redirect |
| psw_we | output | 1 | One-cycle status write enable |
| psw_sm_nx | output | 1 | Mode bit to write |
| psw_ie_nx | output | 1 | Interrupt-enable bit to write |
| psw_c_nx | output | 1 | Carry bit to write |
| bk_sm | output | 1 | Shadow of the mode bit |
| bk_ie | output | 1 | Shadow of the interrupt-enable bit |
| bk_c | output | 1 | Shadow of the carry bit |
| bpc | output | 32 | Backup PC of the faulting instruction |

## Verification
A wrong size decode or a missing return gate shows up in the same cycle, on `fault_taken`, the memory strobes or `irq_take`. A wrong capture or update of the shadow state shows up one edge later, on `bpc`, the shadow bits or the status write values. A wrong restore shows up only at the next return, as a bad redirect target or wrong restored bits. For that reason the bench pairs each entry with a return and checks the word-aligned target for both a word-aligned and a halfword-offset faulting PC.

// File: rtl/afe_pkg.sv
package afe_pkg;

    typedef enum logic [3:0] {
        K_LDB    = 4'd0,
        K_LDUB   = 4'd1,
        K_STB    = 4'd2,
        K_LDH    = 4'd3,
        K_LDUH   = 4'd4,
        K_STH    = 4'd5,
        K_LDW    = 4'd6,
        K_STW    = 4'd7,
        K_LOCK   = 4'd8,
        K_UNLOCK = 4'd9
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_NONE,
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } acc_size_e;

    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } psw_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic acc_size_e size_of(input acc_kind_e k);
        case (k)
            K_LDB, K_LDUB, K_STB:            size_of = SZ_BYTE;
            K_LDH, K_LDUH, K_STH:            size_of = SZ_HALF;
            K_LDW, K_STW, K_LOCK, K_UNLOCK:  size_of = SZ_WORD;
            default:                         size_of = SZ_NONE;
        endcase
    endfunction

    function automatic strobe_t dir_of(input acc_kind_e k);
        strobe_t s;
        s = '0;
        case (k)
            K_LDB, K_LDUB, K_LDH, K_LDUH, K_LDW, K_LOCK: s.rd = 1'b1;
            K_STB, K_STH, K_STW, K_UNLOCK:               s.wr = 1'b1;
            default:                                     s = '0;
        endcase
        return s;
    endfunction

    function automatic logic is_misaligned(input acc_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_HALF: is_misaligned = lo[0];
            SZ_WORD: is_misaligned = |lo;
            default: is_misaligned = 1'b0;
        endcase
    endfunction

    function automatic psw_t entry_psw(input psw_t cur);
        psw_t n;
        n.sm = cur.sm;
        n.ie = 1'b0;
        n.c  = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/afe_access_arbiter.sv
module afe_access_arbiter
    import afe_pkg::*;
(
    input  logic       acc_valid,
    input  logic [3:0] acc_kind,
    input  logic [1:0] addr_lo,
    input  logic       rte_strobe,
    input  logic       irq_req,
    input  logic       irq_en,
    output logic       fault,
    output strobe_t    strobe,
    output logic       irq_take
);
    acc_kind_e kind;
    acc_size_e size;
    strobe_t   dir;
    logic      live;

    always_comb begin
        kind  = acc_kind_e'(acc_kind);
        size  = size_of(kind);
        dir   = dir_of(kind);
        live  = acc_valid && !rte_strobe && (size != SZ_NONE);
        fault = live && is_misaligned(size, addr_lo);
        strobe = (live && !fault) ? dir : '0;
        irq_take = irq_req && irq_en && !fault && !rte_strobe;
    end
endmodule

// File: rtl/afe_backup_bank.sv
module afe_backup_bank
    import afe_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [XLEN-1:0] pc_in,
    input  psw_t            psw_in,
    output logic [XLEN-1:0] bpc,
    output psw_t            bpsw
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bpc  <= '0;
            bpsw <= '0;
        end else if (capture) begin
            bpc  <= pc_in;
            bpsw <= psw_in;
        end
    end
endmodule

// File: rtl/afe_redirect_gen.sv
module afe_redirect_gen
    import afe_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              ALIGN_BITS = 2,
    parameter logic [XLEN-1:0] VEC_ADDR   = 32'h0000_0030
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enter,
    input  logic            leave,
    input  psw_t            psw_cur,
    input  psw_t            psw_saved,
    input  logic [XLEN-1:0] pc_saved,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            psw_we,
    output psw_t            psw_nx
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << ALIGN_BITS) - XLEN'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
            psw_we      <= 1'b0;
            psw_nx      <= '0;
        end else begin
            redirect <= enter || leave;
            psw_we   <= enter || leave;
            if (leave) begin
                redirect_pc <= pc_saved & ALIGN_MASK;
                psw_nx      <= psw_saved;
            end else if (enter) begin
                redirect_pc <= VEC_ADDR;
                psw_nx      <= entry_psw(psw_cur);
            end
        end
    end
endmodule

// File: rtl/align_fault_ctrl.sv
module align_fault_ctrl
    import afe_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0030
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [3:0]      acc_kind,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            psw_sm,
    input  logic            psw_ie,
    input  logic            psw_c,
    input  logic            irq_req,
    input  logic            rte_strobe,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            fault_taken,
    output logic            irq_take,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            psw_we,
    output logic            psw_sm_nx,
    output logic            psw_ie_nx,
    output logic            psw_c_nx,
    output logic            bk_sm,
    output logic            bk_ie,
    output logic            bk_c,
    output logic [XLEN-1:0] bpc
);
    localparam int ALIGN_BITS = 2;

    psw_t    psw_live;
    psw_t    psw_shadow;
    psw_t    psw_next;
    strobe_t strobe;
    logic    fault;

    assign psw_live = '{sm: psw_sm, ie: psw_ie, c: psw_c};

    afe_access_arbiter u_arb (
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .addr_lo   (acc_addr[ALIGN_BITS-1:0]),
        .rte_strobe(rte_strobe),
        .irq_req   (irq_req),
        .irq_en    (psw_ie),
        .fault     (fault),
        .strobe    (strobe),
        .irq_take  (irq_take)
    );

    afe_backup_bank #(.XLEN(XLEN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .capture(fault),
        .pc_in  (cur_pc),
        .psw_in (psw_live),
        .bpc    (bpc),
        .bpsw   (psw_shadow)
    );

    afe_redirect_gen #(
        .XLEN      (XLEN),
        .ALIGN_BITS(ALIGN_BITS),
        .VEC_ADDR  (VEC_ADDR)
    ) u_redir (
        .clk        (clk),
        .rst        (rst),
        .enter      (fault),
        .leave      (rte_strobe),
        .psw_cur    (psw_live),
        .psw_saved  (psw_shadow),
        .pc_saved   (bpc),
        .redirect   (redirect),
        .redirect_pc(redirect_pc),
        .psw_we     (psw_we),
        .psw_nx     (psw_next)
    );

    assign mem_rd      = strobe.rd;
    assign mem_wr      = strobe.wr;
    assign fault_taken = fault;
    assign psw_sm_nx   = psw_next.sm;
    assign psw_ie_nx   = psw_next.ie;
    assign psw_c_nx    = psw_next.c;
    assign bk_sm       = psw_shadow.sm;
    assign bk_ie       = psw_shadow.ie;
    assign bk_c        = psw_shadow.c;
endmodule

// File: rtl/align_fault_ctrl_chk.sv
module align_fault_ctrl_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0030
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic            rte_strobe,
    input logic            psw_sm,
    input logic            psw_ie,
    input logic            psw_c,
    input logic [XLEN-1:0] cur_pc,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            fault_taken,
    input logic            irq_take,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic            psw_we,
    input logic            psw_sm_nx,
    input logic            psw_ie_nx,
    input logic            psw_c_nx,
    input logic            bk_sm,
    input logic            bk_ie,
    input logic            bk_c,
    input logic [XLEN-1:0] bpc
);
    // R4
    fault_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken |-> !mem_rd && !mem_wr);

    // R5
    fault_beats_irq_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken |-> !irq_take);

    // R6
    shadow_capture_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken |=> bk_sm == $past(psw_sm) && bk_ie == $past(psw_ie) && bk_c == $past(psw_c));

    // R7
    entry_psw_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken && !rte_strobe |=> psw_we && psw_sm_nx == $past(psw_sm) && !psw_ie_nx && !psw_c_nx);

    // R8
    bpc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken |=> bpc == $past(cur_pc));

    // R9
    vector_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        fault_taken |=> redirect && redirect_pc == VEC_ADDR);

    // R10
    return_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        rte_strobe |=> redirect && redirect_pc[1:0] == 2'b00 && redirect_pc[XLEN-1:2] == bpc[XLEN-1:2]);

    // R12
    return_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        rte_strobe |-> !fault_taken && !mem_rd && !mem_wr && !irq_take);

    // R11
    return_keeps_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        rte_strobe |=> $stable(bpc) && $stable(bk_sm) && $stable(bk_ie) && $stable(bk_c));

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));
endmodule

bind align_fault_ctrl align_fault_ctrl_chk #(.XLEN(XLEN), .VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/align_fault_ctrl_test.sv
module align_fault_ctrl_test;
    localparam int XLEN = 32;
    localparam logic [31:0] VEC = 32'h0000_0030;
    localparam int NVEC = 16;
    // {kind[3:0], addr_lo[1:0], exp_fault, exp_rd, exp_wr}
    localparam logic [8:0] VTAB [NVEC] = '{
        {4'd0, 2'b11, 3'b010},   // R3
        {4'd1, 2'b01, 3'b010},   // R3
        {4'd2, 2'b11, 3'b001},   // R3
        {4'd3, 2'b00, 3'b010},   // R1
        {4'd3, 2'b01, 3'b100},   // R1
        {4'd4, 2'b11, 3'b100},   // R1
        {4'd4, 2'b10, 3'b010},   // R1
        {4'd5, 2'b10, 3'b001},   // R1
        {4'd5, 2'b01, 3'b100},   // R1
        {4'd6, 2'b00, 3'b010},   // R2
        {4'd6, 2'b10, 3'b100},   // R2
        {4'd7, 2'b11, 3'b100},   // R2
        {4'd8, 2'b10, 3'b100},   // R2
        {4'd8, 2'b00, 3'b010},   // R2
        {4'd9, 2'b01, 3'b100},   // R2
        {4'd9, 2'b00, 3'b001}    // R2
    };

    logic clk = 1'b0;
    logic rst;
    logic acc_valid, irq_req, rte_strobe;
    logic [3:0] acc_kind;
    logic [31:0] acc_addr, cur_pc;
    logic psw_sm, psw_ie, psw_c;
    logic mem_rd, mem_wr, fault_taken, irq_take, redirect, psw_we;
    logic psw_sm_nx, psw_ie_nx, psw_c_nx, bk_sm, bk_ie, bk_c;
    logic [31:0] redirect_pc, bpc;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    align_fault_ctrl #(.XLEN(XLEN), .VEC_ADDR(VEC)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_kind = 0; acc_addr = 0; irq_req = 0; rte_strobe = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(); cur_pc = 0; psw_sm = 0; psw_ie = 0; psw_c = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 redirect", 32'(redirect), 0);
        chk("R13 psw_we", 32'(psw_we), 0);
        chk("R13 bpc", bpc, 0);
        chk("R13 shadow", {29'd0, bk_sm, bk_ie, bk_c}, 0);
        rst = 0;

        // table walk: R1 R2 R3 R4, with fault follow-up R9
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            acc_valid = 1; acc_kind = VTAB[i][8:5];
            acc_addr = {28'h1000_000, 2'b00, VTAB[i][4:3]};
            cur_pc = 32'h200 + 32'(4 * i);
            #1;
            chk($sformatf("R1/R2/R3 fault vec%0d", i), 32'(fault_taken), 32'(VTAB[i][2]));
            chk($sformatf("R4 strobes vec%0d", i), {30'd0, mem_rd, mem_wr}, {30'd0, VTAB[i][1:0]});
            @(negedge clk);
            idle();
            #1;
            if (VTAB[i][2]) chk($sformatf("R9 vector vec%0d", i), redirect_pc, VEC);
            chk($sformatf("R9 redirect vec%0d", i), 32'(redirect), 32'(VTAB[i][2]));
        end

        // R5 interrupt accepted without fault
        @(negedge clk);
        psw_ie = 1; irq_req = 1; acc_valid = 1; acc_kind = 4'd6; acc_addr = 32'h40;
        #1;
        chk("R5 irq accepted", 32'(irq_take), 1);

        // R5 fault beats interrupt; entry captures (halfword-offset PC)
        @(negedge clk);
        psw_sm = 1; psw_ie = 1; psw_c = 1; cur_pc = 32'h0000_1006;
        acc_kind = 4'd7; acc_addr = 32'h42; irq_req = 1;
        #1;
        chk("R5 fault over irq", 32'(irq_take), 0);
        chk("R4 suppressed", {30'd0, mem_rd, mem_wr}, 0);
        @(negedge clk);
        idle(); psw_sm = 0; psw_ie = 0; psw_c = 1;
        #1;
        chk("R8 bpc exact", bpc, 32'h0000_1006);
        chk("R8 bpc bit1", 32'(bpc[1]), 1);
        chk("R6 shadow", {29'd0, bk_sm, bk_ie, bk_c}, 32'b111);
        chk("R7 psw_we", 32'(psw_we), 1);
        chk("R7 new psw", {29'd0, psw_sm_nx, psw_ie_nx, psw_c_nx}, 32'b100);
        @(negedge clk);
        #1;
        chk("R7 single pulse", 32'(psw_we), 0);
        chk("R9 single pulse", 32'(redirect), 0);

        // R12 return cycle blocks misaligned access and irq
        @(negedge clk);
        rte_strobe = 1; acc_valid = 1; acc_kind = 4'd3; acc_addr = 32'h1; irq_req = 1; psw_ie = 1;
        cur_pc = 32'h0000_2000;
        #1;
        chk("R12 no fault", 32'(fault_taken), 0);
        chk("R12 no strobe", {30'd0, mem_rd, mem_wr}, 0);
        chk("R12 no irq", 32'(irq_take), 0);
        @(negedge clk);
        idle(); psw_ie = 0;
        #1;
        chk("R10 redirect", 32'(redirect), 1);
        chk("R10 aligned target", redirect_pc, 32'h0000_1004);
        chk("R11 psw_we", 32'(psw_we), 1);
        chk("R11 restored", {29'd0, psw_sm_nx, psw_ie_nx, psw_c_nx}, 32'b111);
        chk("R11 shadow kept", {29'd0, bk_sm, bk_ie, bk_c}, 32'b111);
        chk("R11 bpc kept", bpc, 32'h0000_1006);

        // word-aligned faulting PC, different status pattern, round trip
        @(negedge clk);
        psw_sm = 0; psw_ie = 1; psw_c = 0; cur_pc = 32'h0000_3004;
        acc_valid = 1; acc_kind = 4'd8; acc_addr = 32'h13;
        @(negedge clk);
        idle();
        #1;
        chk("R8 bpc aligned", bpc, 32'h0000_3004);
        chk("R6 shadow 2", {29'd0, bk_sm, bk_ie, bk_c}, 32'b010);
        chk("R7 new psw 2", {29'd0, psw_sm_nx, psw_ie_nx, psw_c_nx}, 32'b000);
        @(negedge clk);
        rte_strobe = 1;
        @(negedge clk);
        idle();
        #1;
        chk("R10 aligned target 2", redirect_pc, 32'h0000_3004);
        chk("R11 restored 2", {29'd0, psw_sm_nx, psw_ie_nx, psw_c_nx}, 32'b010);

        // R13 reset clears captured state
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        #1;
        chk("R13 bpc cleared", bpc, 0);
        chk("R13 shadow cleared", {29'd0, bk_sm, bk_ie, bk_c}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule